// File: doc/BRIEF.md
# Half-Precision to 16-bit Integer Converter

This unit turns IEEE 754 half-precision values into 16-bit integers, signed or unsigned, under one of five rounding rules. A 7-bit operation code carries both the signedness and the rounding rule. One transfer converts a vector of half-precision lanes or a single scalar lane. The results for all lanes appear together one clock after the input strobe.

Values outside the target range are clamped to the nearest representable integer and raise an invalid flag. A NaN input converts to zero and also raises invalid. A rounded result that differs from the exact input raises an inexact flag. Both flags are sticky and stay set until a clear input empties them. The unit is meant to sit behind a vector register read port. Software sets the rounding rule in the operation code and reads the flags later as a cumulative status.

Top module: `h2i_convert_unit`

## Requirements
- R1: Signed conversion is selected by opcodes 0x1a (nearest, ties to even), 0x1b (toward minus infinity), 0x1c (nearest, ties away from zero), 0x3a (toward plus infinity) and 0x3b (toward zero).
- R2: Unsigned conversion is selected by opcodes 0x5a, 0x5b, 0x5c, 0x7a and 0x7b. These use the same five rounding rules as R1, in the same order. Opcode bit 6 distinguishes unsigned from signed.
- R3: Any other opcode sets `op_illegal` with the result. All result lanes are then zero, and neither sticky flag changes.
- R4: An input with exponent field bits [14:10] all ones and a nonzero fraction field bits [9:0] is a NaN, whether quiet or signalling. It gives exactly 0 for its lane and raises invalid.
- R5: A value that rounds above the range gives 0x7FFF (signed) or 0xFFFF (unsigned) and raises invalid. A value that rounds below the range gives 0x8000 (signed) or 0x0000 (unsigned) and raises invalid. Infinities follow the same rule.
- R6: A negative input to an unsigned conversion that rounds to zero gives 0 without invalid.
- R7: A non-NaN input whose rounded value differs from its exact value raises inexact, unless its lane raised invalid.
- R8: Subnormal inputs (exponent field zero) round under the selected rule. For example, 0x0001 gives 1 toward plus infinity and 0 under the other rules.
- R9: A negative signed result is the 16-bit two's complement value in its own lane, which is bits [16k+15:16k] for lane k. It never reaches a neighbouring lane.
- R10: With `scalar` low, `wide` high converts all LANES lanes and `wide` low converts the lower LANES/2 lanes. With `scalar` high, only lane 0 is converted. Lanes that are not converted read zero and raise no flag.
- R11: `res_valid`, `res_data` and `op_illegal` update on the clock edge that samples `in_valid`. `res_valid` is high for exactly that one cycle. `res_data` holds its value until the next strobe.
- R12: `flag_invalid` and `flag_inexact` stay set until `flag_clr`. When `flag_clr` and `in_valid` are both high in the same cycle, the old flags are dropped and only the new conversion's flags are kept.
- R13: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start a conversion this cycle |
| opcode | input | 7 | Signedness and rounding rule |
| wide | input | 1 | Vector width select: all lanes when high, half when low |
| scalar | input | 1 | Convert lane 0 only |
| flag_clr | input | 1 | Clear the sticky flags |
| src_data | input | LANES*16 | Half-precision lanes, lane k at bits [16k+15:16k] |
| res_valid | output | 1 | Result strobe |
| res_data | output | LANES*16 | Integer lanes |
| op_illegal | output | 1 | Last opcode was not a conversion |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
The bench builds the unit with the default LANES of 8. This puts both vector widths within reach: the eight-lane form and the four-lane form, whose upper half must stay zero and silent. Each of the ten opcodes is applied to ties, negative ties, subnormals, infinities, NaNs and the range limits. A strided sweep over all half-precision bit patterns is compared against a rounding model written with real arithmetic.

// File: rtl/h2i_pkg.sv
package h2i_pkg;
  localparam int HALF_W   = 16;
  localparam int EXP_W    = 5;
  localparam int FRAC_W   = 10;
  localparam int OP_W     = 7;
  localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
  // fixed-point image: significand shifted by (effective exponent - 1)
  localparam int SIG_W    = FRAC_W + 1;
  localparam int MAX_SH   = (1 << EXP_W) - 3;
  localparam int FIX_W    = SIG_W + MAX_SH;
  localparam int PT_POS   = EXP_BIAS + FRAC_W - 1;

  typedef enum logic [2:0] {
    RND_NEAR_EVEN,
    RND_DOWN,
    RND_NEAR_AWAY,
    RND_UP,
    RND_ZERO
  } rnd_mode_e;

  typedef struct packed {
    logic [HALF_W-1:0] value;
    logic              invalid;
    logic              inexact;
  } lane_res_t;
endpackage

// File: rtl/h2i_op_decode.sv
module h2i_op_decode
  import h2i_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output rnd_mode_e       mode_o,
  output logic            unsigned_o,
  output logic            illegal_o
);
  always_comb begin
    unsigned_o = op_i[OP_W-1];
    illegal_o  = 1'b0;
    mode_o     = RND_ZERO;
    unique case (op_i[OP_W-2:0])
      6'h1a:   mode_o = RND_NEAR_EVEN;
      6'h1b:   mode_o = RND_DOWN;
      6'h1c:   mode_o = RND_NEAR_AWAY;
      6'h3a:   mode_o = RND_UP;
      6'h3b:   mode_o = RND_ZERO;
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/h2i_lane.sv
module h2i_lane
  import h2i_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  input  rnd_mode_e         mode_i,
  input  logic              unsigned_i,
  output lane_res_t         res_o
);
  localparam int INT_W = FIX_W - PT_POS;
  localparam logic [INT_W:0] S_POS_LIM = (INT_W+1)'((1 << (HALF_W - 1)) - 1);
  localparam logic [INT_W:0] S_NEG_LIM = (INT_W+1)'(1 << (HALF_W - 1));

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              special;
  logic              is_nan;
  logic [SIG_W-1:0]  sig;
  logic [EXP_W-1:0]  shamt;
  logic [FIX_W-1:0]  fix;
  logic [INT_W-1:0]  int_part;
  logic              rnd_bit;
  logic              stk_bit;
  logic              inc;
  logic [INT_W:0]    mag;

  assign sign     = half_i[HALF_W-1];
  assign expo     = half_i[HALF_W-2:FRAC_W];
  assign frac     = half_i[FRAC_W-1:0];
  assign special  = &expo;
  assign is_nan   = special && (|frac);
  assign sig      = {|expo, frac};
  assign shamt    = (expo == '0) ? '0 : expo - 1'b1;
  assign fix      = FIX_W'(sig) << shamt;
  assign int_part = fix[FIX_W-1:PT_POS];
  assign rnd_bit  = fix[PT_POS-1];
  assign stk_bit  = |fix[PT_POS-2:0];

  always_comb begin
    unique case (mode_i)
      RND_NEAR_EVEN: inc = rnd_bit && (stk_bit || int_part[0]);
      RND_NEAR_AWAY: inc = rnd_bit;
      RND_UP:        inc = !sign && (rnd_bit || stk_bit);
      RND_DOWN:      inc = sign && (rnd_bit || stk_bit);
      default:       inc = 1'b0;
    endcase
  end

  assign mag = {1'b0, int_part} + (INT_W+1)'(inc);

  always_comb begin
    res_o.value   = '0;
    res_o.invalid = 1'b0;
    res_o.inexact = 1'b0;
    if (is_nan) begin
      res_o.invalid = 1'b1;
    end else if (unsigned_i) begin
      if (sign) begin
        if (special || mag != '0) res_o.invalid = 1'b1;
        else                      res_o.inexact = rnd_bit || stk_bit;
      end else if (special || mag[INT_W]) begin
        res_o.value   = '1;
        res_o.invalid = 1'b1;
      end else begin
        res_o.value   = mag[HALF_W-1:0];
        res_o.inexact = rnd_bit || stk_bit;
      end
    end else begin
      if (!sign) begin
        if (special || mag > S_POS_LIM) begin
          res_o.value   = S_POS_LIM[HALF_W-1:0];
          res_o.invalid = 1'b1;
        end else begin
          res_o.value   = mag[HALF_W-1:0];
          res_o.inexact = rnd_bit || stk_bit;
        end
      end else begin
        if (special || mag > S_NEG_LIM) begin
          res_o.value   = S_NEG_LIM[HALF_W-1:0];
          res_o.invalid = 1'b1;
        end else begin
          res_o.value   = ~mag[HALF_W-1:0] + 16'd1;
          res_o.inexact = rnd_bit || stk_bit;
        end
      end
    end
  end
endmodule

// File: rtl/h2i_convert_unit.sv
module h2i_convert_unit
  import h2i_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [OP_W-1:0]         opcode,
  input  logic                    wide,
  input  logic                    scalar,
  input  logic                    flag_clr,
  input  logic [LANES*HALF_W-1:0] src_data,
  output logic                    res_valid,
  output logic [LANES*HALF_W-1:0] res_data,
  output logic                    op_illegal,
  output logic                    flag_invalid,
  output logic                    flag_inexact
);
  localparam int HALF_LANES = LANES / 2;
  localparam int DATA_W     = LANES * HALF_W;

  rnd_mode_e          mode;
  logic               is_uns;
  logic               dec_illegal;
  logic [LANES-1:0]   active;
  logic [LANES-1:0]   inv_vec;
  logic [LANES-1:0]   inx_vec;
  logic [DATA_W-1:0]  next_data;

  h2i_op_decode u_dec (
    .op_i       (opcode),
    .mode_o     (mode),
    .unsigned_o (is_uns),
    .illegal_o  (dec_illegal)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit IN_LOW = (g < HALF_LANES);
    localparam bit IS_L0  = (g == 0);
    lane_res_t lr;
    logic      use_lane;

    h2i_lane u_lane (
      .half_i     (src_data[g*HALF_W +: HALF_W]),
      .mode_i     (mode),
      .unsigned_i (is_uns),
      .res_o      (lr)
    );

    assign active[g]  = scalar ? IS_L0 : (wide || IN_LOW);
    assign use_lane   = active[g] && !dec_illegal;
    assign inv_vec[g] = use_lane && lr.invalid;
    assign inx_vec[g] = use_lane && lr.inexact;
    assign next_data[g*HALF_W +: HALF_W] = use_lane ? lr.value : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      op_illegal   <= 1'b0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_data   <= next_data;
        op_illegal <= dec_illegal;
      end
      flag_invalid <= (flag_invalid && !flag_clr) || (in_valid && (|inv_vec));
      flag_inexact <= (flag_inexact && !flag_clr) || (in_valid && (|inx_vec));
    end
  end

  AST_NAN_LANE0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec_illegal && (&src_data[14:10]) && (|src_data[9:0]))
      |=> (res_data[HALF_W-1:0] == '0) && flag_invalid); // R4

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_illegal) |=> (res_data == '0) && op_illegal); // R3

  AST_ILLEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_illegal && !flag_clr)
      |=> (flag_invalid == $past(flag_invalid)) && (flag_inexact == $past(flag_inexact))); // R3

  AST_STICKY_INVALID: assert property (@(posedge clk) disable iff (rst)
    (flag_invalid && !flag_clr) |=> flag_invalid); // R12

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !in_valid) |=> (!flag_invalid && !flag_inexact)); // R12

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_data) && !res_valid)); // R11

  AST_SCALAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar) |=> (res_data[DATA_W-1:HALF_W] == '0)); // R10

  AST_SIGNED_POS_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec_illegal && !opcode[OP_W-1] && !src_data[HALF_W-1])
      |=> !res_data[HALF_W-1]); // R5
endmodule

// File: tb/sim_h2i_convert_unit.sv
module sim_h2i_convert_unit;
  localparam int LANES = 8;
  localparam int DW    = LANES * 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [6:0]    opcode = '0;
  logic          wide = 1'b0;
  logic          scalar = 1'b0;
  logic          flag_clr = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          res_valid;
  logic [DW-1:0] res_data;
  logic          op_illegal;
  logic          flag_invalid;
  logic          flag_inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  h2i_convert_unit #(.LANES(LANES)) u0 (
    .clk, .rst, .in_valid, .opcode, .wide, .scalar, .flag_clr,
    .src_data, .res_valid, .res_data, .op_illegal, .flag_invalid, .flag_inexact
  );

  bit [6:0] ops [10] = '{7'h1a, 7'h1b, 7'h1c, 7'h3a, 7'h3b,
                         7'h5a, 7'h5b, 7'h5c, 7'h7a, 7'h7b};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane(input int k);
    return res_data[k*16 +: 16];
  endfunction

  // mode index: 0 ties-even, 1 down, 2 ties-away, 3 up, 4 zero
  function automatic int mode_of(input logic [6:0] op);
    case (op[5:0])
      6'h1a: return 0;
      6'h1b: return 1;
      6'h1c: return 2;
      6'h3a: return 3;
      default: return 4;
    endcase
  endfunction

  // returns {invalid, inexact, value}
  function automatic logic [17:0] ref_conv(input logic [15:0] h, input bit uns, input int md);
    int   e = int'(h[14:10]);
    int   f = int'(h[9:0]);
    real  v, fl, ce, r, d, hi, lo;
    logic [15:0] val;
    if (e == 31 && f != 0) return {2'b10, 16'h0000};
    if (e == 31) v = 1.0e9;
    else if (e == 0) v = real'(f) * (2.0 ** real'(1 - 25));
    else v = real'(1024 + f) * (2.0 ** real'(e - 25));
    if (h[15]) v = -v;
    fl = $floor(v);
    ce = $ceil(v);
    d  = v - fl;
    case (md)
      0: r = (d > 0.5) ? ce : (d < 0.5) ? fl : ((($rtoi(fl) % 2) == 0) ? fl : ce);
      1: r = fl;
      2: r = (d > 0.5) ? ce : (d < 0.5) ? fl : ((v >= 0.0) ? ce : fl);
      3: r = ce;
      default: r = (v < 0.0) ? ce : fl;
    endcase
    hi = uns ? 65535.0 : 32767.0;
    lo = uns ? 0.0 : -32768.0;
    if (r > hi) return {2'b10, uns ? 16'hFFFF : 16'h7FFF};
    if (r < lo) return {2'b10, uns ? 16'h0000 : 16'h8000};
    val = 16'($rtoi(r));
    return {1'b0, (r != v), val};
  endfunction

  task automatic apply(input logic [6:0] op, input logic wd, input logic sc,
                       input logic clr, input logic [DW-1:0] s);
    @(negedge clk);
    opcode = op; wide = wd; scalar = sc; flag_clr = clr; src_data = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic check_ref(input logic [6:0] op, input logic wd, input logic sc,
                           input logic [DW-1:0] s, input string req);
    bit ei = 0, ex = 0;
    apply(op, wd, sc, 1'b1, s);
    for (int k = 0; k < LANES; k++) begin
      bit act = sc ? (k == 0) : (wd || k < LANES/2);
      logic [17:0] rr = ref_conv(s[k*16 +: 16], op[6], mode_of(op));
      logic [15:0] ev = act ? rr[15:0] : 16'h0;
      if (act) begin ei |= rr[17]; ex |= rr[16]; end
      chk(lane(k) == ev, $sformatf("%s lane%0d op%0h in%0h", req, k, op, s[k*16 +: 16]), lane(k), ev);
    end
    chk(flag_invalid == ei, {req, " invalid"}, flag_invalid, ei);
    chk(flag_inexact == ex, {req, " inexact"}, flag_inexact, ex);
  endtask

  function automatic logic [DW-1:0] splat(input logic [15:0] h);
    logic [DW-1:0] s;
    for (int k = 0; k < LANES; k++) s[k*16 +: 16] = h;
    return s;
  endfunction

  task automatic t_reset();
    chk(res_valid == 0 && op_illegal == 0, "R13 strobes", {res_valid, op_illegal}, 0);
    chk(res_data == '0, "R13 data", res_data[31:0], 0);
    chk(flag_invalid == 0 && flag_inexact == 0, "R13 flags", {flag_invalid, flag_inexact}, 0);
  endtask

  task automatic t_signed_modes();
    logic [15:0] exp_pos [5] = '{16'd2, 16'd2, 16'd3, 16'd3, 16'd2};
    logic [15:0] exp_neg [5] = '{16'hFFFE, 16'hFFFD, 16'hFFFD, 16'hFFFE, 16'hFFFE};
    logic [15:0] exp_one [5] = '{16'd2, 16'd1, 16'd2, 16'd2, 16'd1};
    for (int m = 0; m < 5; m++) begin
      apply(ops[m], 1'b1, 1'b0, 1'b1, {80'h0, 16'h3E00, 16'hC100, 16'h4100});
      chk(lane(0) == exp_pos[m], "R1 +2.5", lane(0), exp_pos[m]);
      chk(lane(1) == exp_neg[m], "R1 -2.5", lane(1), exp_neg[m]);
      chk(lane(2) == exp_one[m], "R1 +1.5", lane(2), exp_one[m]);
      chk(op_illegal == 0, "R1 legal", op_illegal, 0);
    end
  endtask

  task automatic t_unsigned_modes();
    logic [15:0] exp_pos [5] = '{16'd2, 16'd2, 16'd3, 16'd3, 16'd2};
    logic [15:0] exp_one [5] = '{16'd2, 16'd1, 16'd2, 16'd2, 16'd1};
    for (int m = 0; m < 5; m++) begin
      apply(ops[5+m], 1'b1, 1'b0, 1'b1, {96'h0, 16'h3E00, 16'h4100});
      chk(lane(0) == exp_pos[m], "R2 +2.5", lane(0), exp_pos[m]);
      chk(lane(1) == exp_one[m], "R2 +1.5", lane(1), exp_one[m]);
      chk(op_illegal == 0, "R2 legal", op_illegal, 0);
    end
  endtask

  task automatic t_nan();
    apply(7'h1a, 1'b1, 1'b0, 1'b1, {64'h0, 16'h7C01, 16'h4200, 16'hFC01, 16'h7E00});
    chk(lane(0) == 0 && lane(1) == 0 && lane(3) == 0, "R4 nan zero", {lane(1), lane(0)}, 0);
    chk(lane(2) == 3, "R4 neighbour", lane(2), 3);
    chk(flag_invalid == 1 && flag_inexact == 0, "R4 flags", {flag_invalid, flag_inexact}, 2'b10);
  endtask

  task automatic t_saturate();
    apply(7'h3b, 1'b0, 1'b1, 1'b1, {112'h0, 16'h7C00});
    chk(lane(0) == 16'h7FFF && flag_invalid, "R5 +inf signed", lane(0), 16'h7FFF);
    apply(7'h3b, 1'b0, 1'b1, 1'b1, {112'h0, 16'hFC00});
    chk(lane(0) == 16'h8000 && flag_invalid, "R5 -inf signed", lane(0), 16'h8000);
    apply(7'h1a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h78E2});
    chk(lane(0) == 16'h7FFF && flag_invalid, "R5 40000 signed", lane(0), 16'h7FFF);
    apply(7'h5a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h78E2});
    chk(lane(0) == 16'h9C40 && !flag_invalid, "R5 40000 unsigned", lane(0), 16'h9C40);
    apply(7'h7a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h7C00});
    chk(lane(0) == 16'hFFFF && flag_invalid, "R5 +inf unsigned", lane(0), 16'hFFFF);
    apply(7'h5a, 1'b0, 1'b1, 1'b1, {112'h0, 16'hBC00});
    chk(lane(0) == 0 && flag_invalid, "R5 -1 unsigned", lane(0), 0);
  endtask

  task automatic t_neg_unsigned();
    apply(7'h7b, 1'b0, 1'b1, 1'b1, {112'h0, 16'hB400});
    chk(lane(0) == 0, "R6 -0.25 toward zero", lane(0), 0);
    chk(!flag_invalid && flag_inexact, "R6 flags", {flag_invalid, flag_inexact}, 2'b01);
    apply(7'h5b, 1'b0, 1'b1, 1'b1, {112'h0, 16'hB400});
    chk(lane(0) == 0 && flag_invalid && !flag_inexact, "R6 -0.25 down invalid",
        {flag_invalid, flag_inexact}, 2'b10);
  endtask

  task automatic t_inexact();
    apply(7'h1a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h4200});
    chk(lane(0) == 3 && !flag_inexact, "R7 exact 3.0", flag_inexact, 0);
    apply(7'h1a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h4100});
    chk(flag_inexact, "R7 2.5 inexact", flag_inexact, 1);
    apply(7'h1a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h7C00});
    chk(!flag_inexact, "R7 invalid suppresses inexact", flag_inexact, 0);
  endtask

  task automatic t_subnormal();
    apply(7'h3a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h0001});
    chk(lane(0) == 1 && flag_inexact, "R8 tiny up", lane(0), 1);
    for (int m = 0; m < 5; m++) begin
      if (m == 3) continue;
      apply(ops[m], 1'b0, 1'b1, 1'b1, {112'h0, 16'h0001});
      chk(lane(0) == 0, "R8 tiny other", lane(0), 0);
    end
    apply(7'h1b, 1'b0, 1'b1, 1'b1, {112'h0, 16'h8001});
    chk(lane(0) == 16'hFFFF, "R8 -tiny down", lane(0), 16'hFFFF);
  endtask

  task automatic t_lane_isolation();
    apply(7'h3b, 1'b1, 1'b0, 1'b1, {4{16'h4500, 16'hBC00}});
    for (int k = 0; k < LANES; k++)
      chk(lane(k) == ((k % 2 == 0) ? 16'hFFFF : 16'd5), "R9 lane", lane(k), (k % 2 == 0) ? 16'hFFFF : 16'd5);
    apply(7'h3b, 1'b0, 1'b1, 1'b1, {112'h0, 16'hF800});
    chk(lane(0) == 16'h8000 && !flag_invalid, "R9 -32768", lane(0), 16'h8000);
  endtask

  task automatic t_width();
    logic [DW-1:0] s = splat(16'h4200);
    s[5*16 +: 16] = 16'h7E00;
    apply(7'h1a, 1'b0, 1'b0, 1'b1, s);
    for (int k = 0; k < LANES; k++)
      chk(lane(k) == ((k < 4) ? 16'd3 : 16'd0), "R10 narrow", lane(k), (k < 4) ? 3 : 0);
    chk(!flag_invalid, "R10 inactive nan silent", flag_invalid, 0);
    apply(7'h1a, 1'b1, 1'b0, 1'b1, s);
    chk(lane(7) == 3 && lane(5) == 0 && flag_invalid, "R10 wide", lane(7), 3);
    s = splat(16'h7E00);
    s[15:0] = 16'h4200;
    apply(7'h1a, 1'b1, 1'b1, 1'b1, s);
    chk(lane(0) == 3 && res_data[DW-1:16] == '0, "R10 scalar", lane(1), 0);
    chk(!flag_invalid, "R10 scalar flags", flag_invalid, 0);
  endtask

  task automatic t_illegal();
    apply(7'h1d, 1'b1, 1'b0, 1'b1, splat(16'h7E00));
    chk(op_illegal == 1 && res_data == '0, "R3 illegal result", op_illegal, 1);
    chk(!flag_invalid && !flag_inexact, "R3 no flags", {flag_invalid, flag_inexact}, 0);
    apply(7'h3a, 1'b0, 1'b1, 1'b0, {112'h0, 16'h4100});
    chk(op_illegal == 0 && lane(0) == 3, "R3 legal after", op_illegal, 0);
    apply(7'h00, 1'b1, 1'b0, 1'b0, splat(16'h7C00));
    chk(op_illegal && flag_inexact && !flag_invalid, "R3 flags unchanged",
        {flag_invalid, flag_inexact}, 2'b01);
  endtask

  task automatic t_timing();
    logic [15:0] held;
    @(negedge clk);
    opcode = 7'h1a; scalar = 1'b1; flag_clr = 1'b1; src_data = {112'h0, 16'h4500}; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    chk(res_valid && lane(0) == 5, "R11 one cycle", lane(0), 5);
    src_data = {112'h0, 16'h4200};
    held = lane(0);
    @(negedge clk);
    chk(!res_valid, "R11 strobe drops", res_valid, 0);
    chk(lane(0) == held, "R11 held", lane(0), held);
  endtask

  task automatic t_sticky();
    apply(7'h1a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h7E00});
    chk(flag_invalid, "R12 set", flag_invalid, 1);
    apply(7'h1a, 1'b0, 1'b1, 1'b0, {112'h0, 16'h4200});
    chk(flag_invalid && !flag_inexact, "R12 sticky", {flag_invalid, flag_inexact}, 2'b10);
    apply(7'h1a, 1'b0, 1'b1, 1'b0, {112'h0, 16'h4100});
    chk(flag_invalid && flag_inexact, "R12 accumulate", {flag_invalid, flag_inexact}, 2'b11);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk(!flag_invalid && !flag_inexact, "R12 clear", {flag_invalid, flag_inexact}, 0);
    apply(7'h1a, 1'b0, 1'b1, 1'b0, {112'h0, 16'h7E00});
    apply(7'h1a, 1'b0, 1'b1, 1'b1, {112'h0, 16'h4100});
    chk(!flag_invalid && flag_inexact, "R12 clear with strobe", {flag_invalid, flag_inexact}, 2'b01);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 65536; i += 29) begin
      logic [DW-1:0] s;
      for (int k = 0; k < LANES; k++) s[k*16 +: 16] = 16'(i + k * 4099);
      check_ref(ops[(i / 29) % 10], 1'b1, 1'b0, s, (((i / 29) % 10) < 5) ? "R1 sweep" : "R2 sweep");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_signed_modes();
    t_unsigned_modes();
    t_nan();
    t_saturate();
    t_neg_unsigned();
    t_inexact();
    t_subnormal();
    t_lane_isolation();
    t_width();
    t_illegal();
    t_timing();
    t_sticky();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule